// File: doc/BRIEF.md
# Coherent Capture Accumulator

This block folds a stream of complex observation samples into a buffer whose length matches a repeating test waveform. The buffer address returns to zero after each full waveform length, so a given buffer slot always receives samples that sit at the same phase of the waveform. Over N passes the repeated test content adds up in amplitude, which raises its power by N², while traffic that is not correlated with the waveform grows much more slowly. A downstream correlator reads the finished buffer. Generating the waveform itself is outside this block.

A one-cycle start pulse latches the waveform length (1 to the buffer depth, at most 1023) and the pass count (up to 2²²−1). The capture then takes pass count × length valid samples. On the first pass each sample is stored directly. On every later pass it is added to the stored word. When the last sample has been taken, done rises and the buffer can be read, with one cycle of latency.

Top module: `coh_capture_accum`

## Requirements
- R1: After reset, busy and done are low and both read outputs are zero.
- R2: A start pulse is accepted when busy is low, `len` is between 1 and MAX_LEN, and `iters` is nonzero. From the next cycle busy is high and done is low. `len` and `iters` are captured at that edge.
- R3: A start pulse with `len` of zero or `iters` of zero is ignored: busy stays low and done and the buffer contents are unchanged.
- R4: A sample is taken only on a clock edge where busy and `in_valid` are both high. Samples offered while idle, or with `in_valid` low, leave the buffer unchanged. The write slot starts at 0, advances by one per accepted sample, and returns to 0 after slot len−1.
- R5: After a capture, slot k holds the signed sum, over all passes j, of the sample accepted at position j·len+k. Each sum is sign-extended to DW+ITW bits for I and Q separately. The first pass overwrites whatever an earlier capture left in the slot.
- R6: done rises, and busy falls, on the clock edge that accepts sample number iters·len. done stays high until the next accepted start. busy and done are never high together.
- R7: A start pulse while busy is ignored, and changes on `len` and `iters` during a capture have no effect on that capture.
- R8: `rd_i`/`rd_q` show the slot selected by `rd_addr` one cycle after the edge that samples it. They are zero if done was low at that edge or if `rd_addr` is not below the captured length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle capture request |
| len | input | AW | Waveform length in samples |
| iters | input | ITW | Number of passes |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | DW | Signed in-phase sample |
| in_q | input | DW | Signed quadrature sample |
| rd_addr | input | AW | Buffer read slot |
| rd_i | output | DW+ITW | Accumulated in-phase word |
| rd_q | output | DW+ITW | Accumulated quadrature word |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Buffer complete and readable |

## Verification
The bench builds the block with 8-bit samples, a 7-slot buffer and a 4-bit pass count. With that configuration it can sweep every length from 1 to 7 against pass counts of 1, 2, 5 and the maximum 15. The maximum pass count drives every slot to its full width, so the worst-case sum of −128 × 15 is reached and sign extension is exercised. Every run reuses the buffer left by the previous run, which exposes a first pass that adds instead of overwriting. Idle cycles, stray valid samples, rejected starts and mid-run parameter changes are mixed in, and their effect is read back through the read port.

// File: rtl/coh_capture_accum.sv
module coh_capture_accum #(
  parameter int DW      = 16,
  parameter int MAX_LEN = 1023,
  parameter int ITW     = 22,
  localparam int AW     = $clog2(MAX_LEN + 1),
  localparam int ACCW   = DW + ITW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          len,
  input  logic [ITW-1:0]         iters,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_i,
  input  logic signed [DW-1:0]   in_q,
  input  logic [AW-1:0]          rd_addr,
  output logic signed [ACCW-1:0] rd_i,
  output logic signed [ACCW-1:0] rd_q,
  output logic                   busy,
  output logic                   done
);

  logic signed [ACCW-1:0] mem_i [MAX_LEN];
  logic signed [ACCW-1:0] mem_q [MAX_LEN];

  logic [AW-1:0]  addr, len_q;
  logic [ITW-1:0] pass, iters_q;

  logic go, take, wrap, last, first;
  logic signed [ACCW-1:0] ext_i, ext_q;

  assign go    = !busy && start && (len != '0) && (len <= AW'(MAX_LEN)) && (iters != '0);
  assign take  = busy && in_valid;
  assign wrap  = (addr == len_q - AW'(1));
  assign last  = wrap && (pass == iters_q - ITW'(1));
  assign first = (pass == '0);
  assign ext_i = ACCW'(in_i);
  assign ext_q = ACCW'(in_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      addr    <= '0;
      pass    <= '0;
      len_q   <= '0;
      iters_q <= '0;
    end else if (go) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      addr    <= '0;
      pass    <= '0;
      len_q   <= len;
      iters_q <= iters;
    end else if (take) begin
      if (wrap) begin
        addr <= '0;
        pass <= pass + ITW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        addr <= addr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      mem_i[addr] <= first ? ext_i : mem_i[addr] + ext_i;
      mem_q[addr] <= first ? ext_q : mem_q[addr] + ext_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_i <= '0;
      rd_q <= '0;
    end else if (done && rd_addr < len_q) begin
      rd_i <= mem_i[rd_addr];
      rd_q <= mem_q[rd_addr];
    end else begin
      rd_i <= '0;
      rd_q <= '0;
    end
  end

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (addr < len_q) && (pass < iters_q));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (len_q == $past(len_q)) && (iters_q == $past(iters_q)));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy) && $past(in_valid));

  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (rd_i == '0) && (rd_q == '0));

  // R3
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (len == '0 || iters == '0)) |=> !busy && (done == $past(done)));

endmodule

// File: tb/coh_capture_accum_bench.sv
module coh_capture_accum_bench;
  localparam int DW = 8, ML = 7, ITW = 4, AW = 3, ACCW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] len = '0, rd_addr = '0;
  logic [ITW-1:0] iters = '0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic signed [ACCW-1:0] rd_i, rd_q;
  logic busy, done;

  int n_chk = 0, n_fail = 0;
  int exp_i [ML];
  int exp_q [ML];
  int cur_len = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  coh_capture_accum #(.DW(DW), .MAX_LEN(ML), .ITW(ITW)) u_coh_capture_accum (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .iters(iters),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .rd_addr(rd_addr),
    .rd_i(rd_i), .rd_q(rd_q), .busy(busy), .done(done));

  function automatic int smp_i(int k, int j, int r);
    return ((k * 37 + j * 11 + r * 53) % 256) - 128;
  endfunction
  function automatic int smp_q(int k, int j, int r);
    return ((k * 13 + j * 29 + r * 71 + 7) % 256) - 128;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_slot(int a, output int vi, output int vq);
    rd_addr = AW'(a);
    @(negedge clk);
    vi = int'(rd_i);
    vq = int'(rd_q);
  endtask

  task automatic verify_buffer(string req);
    int vi, vq;
    for (int k = 0; k < cur_len; k++) begin
      read_slot(k, vi, vq);
      check(req, vi, exp_i[k]);
      check(req, vq, exp_q[k]);
    end
    if (cur_len < ML) begin
      read_slot(cur_len, vi, vq);
      check("R8 beyond length", vi, 0);
      check("R8 beyond length", vq, 0);
    end
  endtask

  task automatic run(int l, int n, int r, bit stray);
    int vi;
    for (int k = 0; k < ML; k++) begin exp_i[k] = 0; exp_q[k] = 0; end
    len = AW'(l); iters = ITW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", int'(busy), 1);
    check("R2 done cleared", int'(done), 0);
    len = AW'((l % ML) + 1); iters = ITW'(1);
    rd_addr = '0;
    for (int j = 0; j < n; j++) begin
      for (int k = 0; k < l; k++) begin
        if ((k + j + r) % 3 == 0) begin
          in_valid = 1'b0; in_i = 8'sd99; in_q = -8'sd77;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_i = DW'(smp_i(k, j, r));
        in_q = DW'(smp_q(k, j, r));
        exp_i[k] += smp_i(k, j, r);
        exp_q[k] += smp_q(k, j, r);
        if (stray && j == 0 && k == 0) start = 1'b1;
        if (j == n - 1 && k == l - 1) check("R6 done low before last", int'(done), 0);
        @(negedge clk);
        start = 1'b0;
        if (j == 0 && k == 0) begin
          vi = int'(rd_i);
          check("R8 gated while busy", vi, 0);
        end
      end
    end
    in_valid = 1'b0;
    check("R6 done after last", int'(done), 1);
    check("R6 busy after last", int'(busy), 0);
    cur_len = l;
    verify_buffer(stray ? "R7 stray start" : "R5 sum");
  endtask

  initial begin
    int vi, vq, r;
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 rd_i", int'(rd_i), 0);
    rst_n = 1'b1;
    @(negedge clk);
    r = 0;
    foreach (exp_i[x]) begin exp_i[x] = 0; exp_q[x] = 0; end
    for (int l = 1; l <= ML; l++) begin
      for (int t = 0; t < 4; t++) begin
        int n;
        n = (t == 0) ? 1 : (t == 1) ? 2 : (t == 2) ? 5 : 15;
        run(l, n, r, (r % 4) == 1);
        r++;
      end
    end
    // R4: valid samples offered while idle must not touch the buffer
    in_valid = 1'b1; in_i = 8'sd100; in_q = 8'sd100;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    verify_buffer("R4 idle samples");
    // R3: zero length, then zero iterations
    len = '0; iters = ITW'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 zero len busy", int'(busy), 0);
    check("R3 zero len done", int'(done), 1);
    len = AW'(2); iters = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 zero iters busy", int'(busy), 0);
    verify_buffer("R3 buffer kept");
    // R5: full-scale negative input at max passes
    len = AW'(1); iters = ITW'(15); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b1; in_i = -8'sd128; in_q = 8'sd127;
    repeat (15) @(negedge clk);
    in_valid = 1'b0;
    check("R6 done extreme", int'(done), 1);
    read_slot(0, vi, vq);
    check("R5 extreme I", vi, -1920);
    check("R5 extreme Q", vq, 1905);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule